// File: doc/BRIEF.md
# Fractional-Rate Tick Divider

This block derives a steady stream of single-cycle enable pulses from a fast system clock whose frequency is not a whole multiple of the wanted tick rate. A typical use is a 32.768 kHz time base taken from a 25 MHz, 50 MHz or 100 MHz clock. The period counter runs for either N or N+1 enabled clocks. A short pattern sequencer chooses the length of each period. Over one full pattern the mean period therefore equals a non-integer ratio, and the difference between any two tick periods is never more than one input clock.

The pattern holds `PAT_LEN` positions, and `SHORT_CNT` of them use the short length N. These short positions are spread evenly over the pattern rather than grouped together. The pattern moves forward by one position on each tick. Consumers gate their logic with `tick` and stay in the system clock domain. Holding `en` low freezes the whole divider.

Top module: `frac_tick_div`

## Requirements
- R1: While `rst` is high, `tick` stays low. After `rst` is released, the first tick arrives at the end of a full period for pattern position 0. The sample taken right after release counts as the first enabled clock of that period.
- R2: `tick` is high for exactly one system clock per period. It is never high on two consecutive clocks.
- R3: Each period lasts N enabled clocks at a short position and N+1 enabled clocks at a long position. `tick` is high on the last clock of the period.
- R4: Pattern position p (0 to PAT_LEN-1) is short exactly when floor((p+1)*SHORT_CNT/PAT_LEN) > floor(p*SHORT_CNT/PAT_LEN). Each pattern therefore has exactly SHORT_CNT short periods.
- R5: The position advances by one on each tick and wraps from PAT_LEN-1 to 0. One full pattern lasts PAT_LEN*(N+1)-SHORT_CNT enabled clocks.
- R6: While `en` is low, `tick` stays low, and both the period count and the pattern position hold their values. The period then resumes where it stopped.
- R7: A reset during operation restarts the divider at position 0 with a full first period.
- R8: With default parameters (N=762, PAT_LEN=31, SHORT_CNT=2), positions 15 and 30 last 762 clocks and all other positions last 763. 31 ticks take 23651 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk  | input  | 1 | System clock |
| rst  | input  | 1 | Synchronous reset, active high |
| en   | input  | 1 | Count enable; low freezes the divider |
| tick | output | 1 | One-clock enable pulse at the end of each period |

## Verification
A reduced configuration (N=5, five positions, two short) is run through more than two full patterns. This shows whether the short positions sit where the spreading rule puts them and whether the pattern wraps correctly. The same sequence is repeated with `en` held low for several clocks in the middle of some periods, which separates a frozen counter from one that keeps running or loses counts. A reset during operation checks that the divider restarts at position 0. The default 25 MHz configuration is then run for one complete 31-tick pattern, checking each period length and the total clock count.

// File: rtl/tick_div_pkg.sv
package tick_div_pkg;

    typedef enum logic {
        SLOT_LONG  = 1'b0,
        SLOT_SHORT = 1'b1
    } slot_kind_e;

    // Even spreading: a slot is short when the running share of short
    // periods crosses a whole number inside that slot.
    function automatic slot_kind_e slot_kind(input int unsigned pos,
                                             input int unsigned shorts,
                                             input int unsigned len);
        if (((pos * shorts) % len) + shorts >= len)
            return SLOT_SHORT;
        return SLOT_LONG;
    endfunction

    function automatic int unsigned pos_width(input int unsigned len);
        return (len > 1) ? $clog2(len) : 1;
    endfunction

endpackage

// File: rtl/tick_pattern_seq.sv
module tick_pattern_seq
    import tick_div_pkg::*;
#(
    parameter int unsigned PAT_LEN   = 31,
    parameter int unsigned SHORT_CNT = 2,
    parameter int unsigned POS_W     = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       adv,
    output slot_kind_e next_kind
);

    generate
        if (PAT_LEN == 1) begin : g_single
            // One-slot pattern: every period has the same length.
            assign next_kind = slot_kind(0, SHORT_CNT, 1);
        end else begin : g_multi
            localparam logic [POS_W-1:0] LAST_POS = POS_W'(PAT_LEN - 1);

            logic [POS_W-1:0] pos_q;
            logic [POS_W-1:0] pos_nxt;
            logic [POS_W:0]   short_seen_q;
            slot_kind_e       cur_kind;

            assign pos_nxt   = (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
            assign next_kind = slot_kind(int'(pos_nxt), SHORT_CNT, PAT_LEN);
            assign cur_kind  = slot_kind(int'(pos_q), SHORT_CNT, PAT_LEN);

            always_ff @(posedge clk) begin
                if (rst) begin
                    pos_q <= '0;
                end else if (adv) begin
                    pos_q <= pos_nxt;
                end
            end

            // Count of short slots finished in the current pattern (for checking).
            always_ff @(posedge clk) begin
                if (rst) begin
                    short_seen_q <= '0;
                end else if (adv) begin
                    if (pos_q == LAST_POS)
                        short_seen_q <= '0;
                    else if (cur_kind == SLOT_SHORT)
                        short_seen_q <= short_seen_q + 1'b1;
                end
            end

            AST_POS_HOLD: assert property (@(posedge clk) disable iff (rst)
                !adv |=> $stable(pos_q)) else $error("position moved without a tick"); // R6
            AST_POS_RANGE: assert property (@(posedge clk) disable iff (rst)
                pos_q <= LAST_POS) else $error("position out of range"); // R5
            AST_SHORT_PER_PATTERN: assert property (@(posedge clk) disable iff (rst)
                (adv && pos_q == LAST_POS) |->
                (int'(short_seen_q) + ((cur_kind == SLOT_SHORT) ? 1 : 0) == int'(SHORT_CNT)))
                else $error("short slot count per pattern wrong"); // R4
        end
    endgenerate

endmodule

// File: rtl/tick_period_ctr.sv
module tick_period_ctr
    import tick_div_pkg::*;
#(
    parameter int unsigned DIV_N      = 762,
    parameter int unsigned CNT_W      = 10,
    parameter slot_kind_e  FIRST_KIND = SLOT_LONG
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  slot_kind_e reload_kind,
    output logic       tick
);

    localparam logic [CNT_W-1:0] LOAD_SHORT = CNT_W'(DIV_N - 1);
    localparam logic [CNT_W-1:0] LOAD_LONG  = CNT_W'(DIV_N);
    localparam logic [CNT_W-1:0] LOAD_FIRST =
        (FIRST_KIND == SLOT_SHORT) ? LOAD_SHORT : LOAD_LONG;

    logic [CNT_W-1:0] cnt_q;

    assign tick = en && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= LOAD_FIRST;
        end else if (en) begin
            if (cnt_q == '0)
                cnt_q <= (reload_kind == SLOT_SHORT) ? LOAD_SHORT : LOAD_LONG;
            else
                cnt_q <= cnt_q - 1'b1;
        end
    end

    AST_CNT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt_q)) else $error("counter moved while disabled"); // R6
    AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt_q == LOAD_SHORT || cnt_q == LOAD_LONG))
        else $error("reload outside N-1..N"); // R3

endmodule

// File: rtl/frac_tick_div.sv
module frac_tick_div
    import tick_div_pkg::*;
#(
    parameter int unsigned DIV_N     = 762,
    parameter int unsigned PAT_LEN   = 31,
    parameter int unsigned SHORT_CNT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);

    localparam int unsigned CNT_W      = $clog2(DIV_N + 1);
    localparam int unsigned POS_W      = pos_width(PAT_LEN);
    localparam slot_kind_e  FIRST_KIND = slot_kind(0, SHORT_CNT, PAT_LEN);

    generate
        if (DIV_N < 2 || PAT_LEN < 1 || SHORT_CNT > PAT_LEN) begin : g_bad_params
            $error("frac_tick_div: need DIV_N >= 2, PAT_LEN >= 1, SHORT_CNT <= PAT_LEN");
        end
    endgenerate

    slot_kind_e next_kind;

    tick_pattern_seq #(
        .PAT_LEN   (PAT_LEN),
        .SHORT_CNT (SHORT_CNT),
        .POS_W     (POS_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .adv       (tick),
        .next_kind (next_kind)
    );

    tick_period_ctr #(
        .DIV_N      (DIV_N),
        .CNT_W      (CNT_W),
        .FIRST_KIND (FIRST_KIND)
    ) u_ctr (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .reload_kind (next_kind),
        .tick        (tick)
    );

    AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick) else $error("tick wider than one clock"); // R2
    AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        tick |-> en) else $error("tick while disabled"); // R6

endmodule

// File: tb/frac_tick_div_tb.sv
module frac_tick_div_tb;

    typedef struct packed {
        int period;  // expected enabled clocks in this period
        int stall;   // disabled clocks inserted after the 2nd enabled clock
    } vec_t;

    // N=5, five slots, two short: short slots at positions 2 and 4.
    localparam int NVEC = 12;
    localparam vec_t VEC [NVEC] = '{
        '{6, 0}, '{6, 3}, '{5, 0}, '{6, 1}, '{5, 0},
        '{6, 0}, '{6, 2}, '{5, 0}, '{6, 0}, '{5, 0},
        '{6, 1}, '{6, 0}
    };

    logic clk = 1'b0;
    logic rst, en, tick;
    logic rst_d, en_d, tick_d;

    int checks = 0;
    int fails  = 0;
    bit reported = 0;

    always #2 clk = ~clk;

    frac_tick_div #(.DIV_N(5), .PAT_LEN(5), .SHORT_CNT(2)) u_dut (
        .clk(clk), .rst(rst), .en(en), .tick(tick)
    );

    frac_tick_div u_dut_dflt (
        .clk(clk), .rst(rst_d), .en(en_d), .tick(tick_d)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    task automatic step(input logic e, output logic t);
        en = e;
        #1;
        t = tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Runs one period; counts enabled clocks up to and including the tick.
    task automatic run_period(input string req, input int exp, input int stall);
        int  n = 0;
        bit  seen = 0;
        logic t;
        while (!seen && n < exp + 2) begin
            if (n == 2 && stall > 0) begin
                for (int s = 0; s < stall; s++) begin
                    step(1'b0, t);
                    chk("R6 tick while en low", int'(t), 0);
                end
            end
            step(1'b1, t);
            n++;
            if (t) seen = 1;
        end
        chk(req, n, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        logic t;
        int n, pos, total, exp_len;
        rst = 1'b1; en = 1'b0; rst_d = 1'b1; en_d = 1'b0;
        repeat (3) @(negedge clk);

        // R1: no tick during reset, even with enable high
        for (int i = 0; i < 3; i++) begin
            step(1'b1, t);
            chk("R1 tick during reset", int'(t), 0);
        end
        rst = 1'b0;

        // R1/R3/R4/R5/R6: vector walk over more than two patterns
        for (int v = 0; v < NVEC; v++)
            run_period("R3/R4/R5 period length", VEC[v].period, VEC[v].stall);

        // R7: reset mid-period, then restart at position 0
        step(1'b1, t);
        step(1'b1, t);
        rst = 1'b1;
        for (int i = 0; i < 2; i++) begin
            step(1'b1, t);
            chk("R7 tick during mid-run reset", int'(t), 0);
        end
        rst = 1'b0;
        run_period("R7 first period after reset", 6, 0);
        run_period("R7 second period after reset", 6, 0);
        run_period("R7 third period after reset", 5, 0);

        // R8: default configuration, one full 31-slot pattern
        en = 1'b0;
        en_d = 1'b1;
        rst_d = 1'b0;
        n = 0; pos = 0; total = 0;
        while (pos < 31) begin
            #1;
            n++;
            total++;
            if (tick_d) begin
                exp_len = (((pos + 1) * 2) / 31 > (pos * 2) / 31) ? 762 : 763;
                chk("R8 default period length", n, exp_len);
                n = 0;
                pos++;
            end
            @(posedge clk);
            @(negedge clk);
        end
        chk("R8 default pattern total", total, 23651);
        report();
    end

endmodule